// File: doc/BRIEF.md
# Host-to-DSP Flag and Word Exchange

This block sits between a byte-wide host bus and a 24-bit DSP register bus. Each side has its own control register. The two flag bits the host writes show up as read-only status bits on the DSP side, and the two flag bits the DSP writes show up as read-only status bits on the host side. The host can also set two mode bits. The OR of these mode bits is a DMA indicator, and bit 7 of both status registers reports it. Any reset source or a stop request clears this indicator.

For data, the host writes three transmit bytes. Writing the low byte marks the word as pending. When the DSP receive register is free, the block packs the three bytes into that register, high byte in the most significant position, and raises a receive-full flag. A DSP read of the receive register clears that flag. The DSP control register holds three interrupt enables. Each enable is ANDed with its status flag, and the results drive a single interrupt request.

All read data is registered. A read returns, one clock after the address is presented, the state from before that clock edge.

Top module: `hflag_xchg`

## Requirements
- R1: After reset, the host status reads 0x06, the DSP status reads 0x02, the host control and the receive register read 0, and `d_irq` is 0.
- R2: Host control bits 0 and 1 (host flags) appear as DSP status bits 3 and 4.
- R3: DSP control bits 3 and 4 (DSP flags) appear as host status bits 3 and 4.
- R4: Host status bit 7 and DSP status bit 7 equal the OR of host control bits 2 and 3 (mode bits). Host control bits above 3 read back as 0.
- R5: A pulse on `stop_req` clears the mode bits and keeps the host flags. A pulse on `soft_rst` or `unit_rst` clears the whole block. Each of these clears bit 7 of both status registers.
- R6: DSP status bits 2, 5 and 6 always read 0. DSP status bit 1 (DSP transmit empty) always reads 1.
- R7: A host write to offset 7 clears host status bit 1 (transmit empty). On the next edge the word {offset 5, offset 6, offset 7} loads into the DSP receive register (DSP offset 2). On the same edge DSP status bit 0 (receive full) is set and transmit empty returns to 1.
- R8: While receive full is 1, a pending word does not move. The receive register keeps its value, and transmit empty stays 0.
- R9: A DSP read at offset 2 with `d_re` set clears receive full. A word that is still pending then transfers on the following edge.
- R10: Host status bit 2 (path ready) equals transmit empty AND NOT receive full.
- R11: `d_irq` is the registered OR of (DSP control bit 0 AND receive full), (bit 1 AND DSP transmit empty) and (bit 2 AND command pending).
- R12: Host writes to offsets 5 and 6 alone do not start a transfer.
- R13: Read data appears one clock after the address. Host offsets 1, 3, 4, 5, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Software reset, clears the block |
| unit_rst | input | 1 | Reset of this interface only, clears the block |
| stop_req | input | 1 | Stop entry, clears the mode bits |
| h_addr | input | 3 | Host register offset |
| h_we | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| d_addr | input | 2 | DSP register offset: 0 control, 1 status, 2 receive |
| d_we | input | 1 | DSP write strobe (control only) |
| d_re | input | 1 | DSP read strobe, side effect at offset 2 |
| d_wdata | input | 24 | DSP write data |
| d_rdata | output | 24 | DSP read data, registered |
| d_irq | output | 1 | DSP interrupt request, registered |

## Verification
The bench uses the default parameters: an 8-bit host lane, three transmit lanes and a 3-bit host address. With three lanes the high, middle and low bytes all differ, so a wrong byte order in the packed word is caught. With three lanes the low byte also lands on the top host offset. A 24-bit DSP word makes a full transfer observable in one read. The bench walks flag and mode combinations through a vector table. It then stalls a second word behind a full receive register and releases it with a DSP read.

// File: rtl/hx_pkg.sv
package hx_pkg;
  // host-side offsets
  localparam int H_CTL = 0;
  localparam int H_STS = 2;
  // DSP-side offsets
  localparam int D_CTL = 0;
  localparam int D_STS = 1;
  localparam int D_RX  = 2;
  // host control fields
  localparam int HC_F0 = 0;
  localparam int HC_F1 = 1;
  localparam int HC_M0 = 2;
  localparam int HC_M1 = 3;
  // host status fields
  localparam int HS_TXE = 1;
  localparam int HS_RDY = 2;
  localparam int HS_D0  = 3;
  localparam int HS_D1  = 4;
  // DSP control fields
  localparam int DC_RXIE = 0;
  localparam int DC_TXIE = 1;
  localparam int DC_CMIE = 2;
  localparam int DC_D0   = 3;
  localparam int DC_D1   = 4;
  localparam int DC_W    = 5;
  // DSP status fields
  localparam int DS_RXF = 0;
  localparam int DS_TXE = 1;
  localparam int DS_CMD = 2;
  localparam int DS_H0  = 3;
  localparam int DS_H1  = 4;
  // shared
  localparam int ST_DMA = 7;
endpackage

// File: rtl/hx_host_regs.sv
module hx_host_regs
  import hx_pkg::*;
#(
  parameter int HW  = 8,
  parameter int NB  = 3,
  parameter int HAW = 3,
  localparam int DW = HW * NB
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           stop_req,
  input  logic [HAW-1:0] h_addr,
  input  logic           h_we,
  input  logic [HW-1:0]  h_wdata,
  input  logic           tx_empty,
  input  logic           rx_full,
  input  logic [1:0]     dflag,
  output logic [1:0]     hflag,
  output logic [1:0]     mode,
  output logic           lo_wr,
  output logic [DW-1:0]  tx_word,
  output logic [HW-1:0]  h_rdata
);
  localparam int TX_BASE = (1 << HAW) - NB;
  localparam logic [HAW-1:0] A_CTL = HAW'(H_CTL);
  localparam logic [HAW-1:0] A_STS = HAW'(H_STS);
  localparam logic [HAW-1:0] A_LO  = HAW'(TX_BASE + NB - 1);

  logic [HW-1:0] rd_mux;

  // control register: flags and mode bits, stop clears the mode bits
  always_ff @(posedge clk) begin
    if (clr) begin
      hflag <= '0;
      mode  <= '0;
    end else begin
      if (h_we && h_addr == A_CTL) begin
        hflag <= {h_wdata[HC_F1], h_wdata[HC_F0]};
        mode  <= {h_wdata[HC_M1], h_wdata[HC_M0]};
      end
      if (stop_req) mode <= '0;
    end
  end

  // transmit lanes, lane 0 is the most significant byte
  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam logic [HAW-1:0] A_LANE = HAW'(TX_BASE + k);
    logic [HW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (clr)                          lane_q <= '0;
      else if (h_we && h_addr == A_LANE) lane_q <= h_wdata;
    end
    assign tx_word[DW-1-k*HW -: HW] = lane_q;
  end

  assign lo_wr = h_we && (h_addr == A_LO);

  always_comb begin
    rd_mux = '0;
    if (h_addr == A_CTL) begin
      rd_mux[HC_F0] = hflag[0];
      rd_mux[HC_F1] = hflag[1];
      rd_mux[HC_M0] = mode[0];
      rd_mux[HC_M1] = mode[1];
    end else if (h_addr == A_STS) begin
      rd_mux[HS_TXE] = tx_empty;
      rd_mux[HS_RDY] = tx_empty & ~rx_full;
      rd_mux[HS_D0]  = dflag[0];
      rd_mux[HS_D1]  = dflag[1];
      rd_mux[ST_DMA] = |mode;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) h_rdata <= '0;
    else     h_rdata <= rd_mux;
  end

  AST_STOP_CLEARS_MODE: assert property (@(posedge clk) disable iff (clr)
    stop_req |=> (mode == 2'b00)); // R5

  AST_CTL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (clr)
    (h_we && h_addr == A_CTL) |=> (hflag == $past(h_wdata[1:0]))); // R2
endmodule

// File: rtl/hx_xfer.sv
module hx_xfer #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          lo_wr,
  input  logic [DW-1:0] tx_word,
  input  logic          rd_clr,
  output logic          tx_empty,
  output logic          rx_full,
  output logic [DW-1:0] rx_data
);
  logic move;
  assign move = !tx_empty && !rx_full;

  always_ff @(posedge clk) begin
    if (clr) begin
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (move) begin
        rx_data <= tx_word;
        rx_full <= 1'b1;
      end else if (rd_clr) begin
        rx_full <= 1'b0;
      end
      if (lo_wr)     tx_empty <= 1'b0;
      else if (move) tx_empty <= 1'b1;
    end
  end

  AST_MOVE_SETS_FLAGS: assert property (@(posedge clk) disable iff (clr)
    (!tx_empty && !rx_full && !lo_wr) |=> (rx_full && tx_empty)); // R7

  AST_FULL_HOLDS_WORD: assert property (@(posedge clk) disable iff (clr)
    (rx_full && !rd_clr) |=> (rx_full && $stable(rx_data))); // R8

  AST_READ_DRAINS: assert property (@(posedge clk) disable iff (clr)
    (rx_full && rd_clr) |=> !rx_full); // R9
endmodule

// File: rtl/hx_dsp_regs.sv
module hx_dsp_regs
  import hx_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [1:0]    d_addr,
  input  logic          d_we,
  input  logic          d_re,
  input  logic [DW-1:0] d_wdata,
  input  logic [1:0]    hflag,
  input  logic          dma,
  input  logic          rx_full,
  input  logic [DW-1:0] rx_data,
  output logic [1:0]    dflag,
  output logic          rd_clr,
  output logic [DW-1:0] d_rdata,
  output logic          d_irq
);
  localparam logic [1:0] A_CTL = 2'(D_CTL);
  localparam logic [1:0] A_STS = 2'(D_STS);
  localparam logic [1:0] A_RX  = 2'(D_RX);

  logic [DC_W-1:0] ctl_q;
  logic [DW-1:0]   rd_mux;
  logic            dsp_tx_empty;
  logic            cmd_pend;
  logic            unused_wbits;

  // DSP-to-host data and command path are outside this block
  assign dsp_tx_empty = 1'b1;
  assign cmd_pend     = 1'b0;
  assign unused_wbits = ^d_wdata[DW-1:DC_W];

  always_ff @(posedge clk) begin
    if (clr)                          ctl_q <= '0;
    else if (d_we && d_addr == A_CTL) ctl_q <= d_wdata[DC_W-1:0];
  end

  assign dflag  = {ctl_q[DC_D1], ctl_q[DC_D0]};
  assign rd_clr = d_re && (d_addr == A_RX);

  always_comb begin
    rd_mux = '0;
    case (d_addr)
      A_CTL: rd_mux[DC_W-1:0] = ctl_q;
      A_STS: begin
        rd_mux[DS_RXF] = rx_full;
        rd_mux[DS_TXE] = dsp_tx_empty;
        rd_mux[DS_CMD] = cmd_pend;
        rd_mux[DS_H0]  = hflag[0];
        rd_mux[DS_H1]  = hflag[1];
        rd_mux[ST_DMA] = dma;
      end
      A_RX:    rd_mux = rx_data;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      d_rdata <= '0;
      d_irq   <= 1'b0;
    end else begin
      d_rdata <= rd_mux;
      d_irq   <= (ctl_q[DC_RXIE] & rx_full)
               | (ctl_q[DC_TXIE] & dsp_tx_empty)
               | (ctl_q[DC_CMIE] & cmd_pend);
    end
  end

  AST_IRQ_ON_FULL: assert property (@(posedge clk) disable iff (clr)
    (ctl_q[DC_RXIE] && rx_full) |=> d_irq); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (clr)
    (ctl_q == '0) |=> !d_irq); // R11
endmodule

// File: rtl/hflag_xchg.sv
module hflag_xchg
  import hx_pkg::*;
#(
  parameter int HW  = 8,
  parameter int NB  = 3,
  parameter int HAW = 3,
  localparam int DW = HW * NB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           soft_rst,
  input  logic           unit_rst,
  input  logic           stop_req,
  input  logic [HAW-1:0] h_addr,
  input  logic           h_we,
  input  logic [HW-1:0]  h_wdata,
  output logic [HW-1:0]  h_rdata,
  input  logic [1:0]     d_addr,
  input  logic           d_we,
  input  logic           d_re,
  input  logic [DW-1:0]  d_wdata,
  output logic [DW-1:0]  d_rdata,
  output logic           d_irq
);
  logic          clr;
  logic [1:0]    hflag, mode, dflag;
  logic          lo_wr, tx_empty, rx_full, rd_clr;
  logic [DW-1:0] tx_word, rx_data;

  assign clr = rst | soft_rst | unit_rst;

  hx_host_regs #(.HW(HW), .NB(NB), .HAW(HAW)) host_i (
    .clk(clk), .clr(clr), .stop_req(stop_req),
    .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .dflag(dflag),
    .hflag(hflag), .mode(mode), .lo_wr(lo_wr),
    .tx_word(tx_word), .h_rdata(h_rdata)
  );

  hx_xfer #(.DW(DW)) xfer_i (
    .clk(clk), .clr(clr), .lo_wr(lo_wr), .tx_word(tx_word),
    .rd_clr(rd_clr), .tx_empty(tx_empty), .rx_full(rx_full),
    .rx_data(rx_data)
  );

  hx_dsp_regs #(.DW(DW)) dsp_i (
    .clk(clk), .clr(clr), .d_addr(d_addr), .d_we(d_we), .d_re(d_re),
    .d_wdata(d_wdata), .hflag(hflag), .dma(|mode), .rx_full(rx_full),
    .rx_data(rx_data), .dflag(dflag), .rd_clr(rd_clr),
    .d_rdata(d_rdata), .d_irq(d_irq)
  );

  AST_RESET_SOURCES_DROP_DMA: assert property (@(posedge clk)
    (soft_rst || unit_rst || stop_req) |=> (mode == 2'b00)); // R5
endmodule

// File: tb/hflag_xchg_tb.sv
`timescale 1ns/1ps
module hflag_xchg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1, soft_rst = 1'b0, unit_rst = 1'b0, stop_req = 1'b0;
  logic [2:0]  h_addr = '0;
  logic        h_we = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic [1:0]  d_addr = '0;
  logic        d_we = 1'b0, d_re = 1'b0;
  logic [23:0] d_wdata = '0;
  logic [23:0] d_rdata;
  logic        d_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hflag_xchg dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .unit_rst(unit_rst),
    .stop_req(stop_req), .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .d_addr(d_addr), .d_we(d_we), .d_re(d_re),
    .d_wdata(d_wdata), .d_rdata(d_rdata), .d_irq(d_irq)
  );

  // {host ctl, dsp ctl, exp host status, exp dsp status, exp irq}
  localparam int NV = 9;
  localparam logic [32:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h06, 8'h02, 1'b0},
    {8'h01, 8'h08, 8'h0E, 8'h0A, 1'b0},
    {8'h02, 8'h10, 8'h16, 8'h12, 1'b0},
    {8'h04, 8'h00, 8'h86, 8'h82, 1'b0},
    {8'h08, 8'h18, 8'h9E, 8'h82, 1'b0},
    {8'h0C, 8'h02, 8'h86, 8'h82, 1'b1},
    {8'h03, 8'h01, 8'h06, 8'h1A, 1'b0},
    {8'h0F, 8'h1F, 8'h9E, 8'h9A, 1'b1},
    {8'hFF, 8'h00, 8'h86, 8'h9A, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] v);
    h_addr = a; h_wdata = v; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] v);
    h_addr = a;
    @(negedge clk);
    v = h_rdata;
  endtask

  task automatic dwr(input logic [1:0] a, input logic [23:0] v);
    d_addr = a; d_wdata = v; d_we = 1'b1;
    @(negedge clk);
    d_we = 1'b0;
  endtask

  task automatic drd(input logic [1:0] a, input logic clr_rd, output logic [23:0] v);
    d_addr = a; d_re = clr_rd;
    @(negedge clk);
    d_re = 1'b0;
    v = d_rdata;
  endtask

  task automatic pulse(input int which);
    if (which == 0) stop_req = 1'b1;
    else if (which == 1) soft_rst = 1'b1;
    else unit_rst = 1'b1;
    @(negedge clk);
    stop_req = 1'b0; soft_rst = 1'b0; unit_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  hv;
    logic [23:0] dv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    hrd(3'd2, hv);        chk("R1 host status", 32'(hv), 32'h06);
    hrd(3'd0, hv);        chk("R1 host ctl", 32'(hv), 32'h00);
    drd(2'd1, 1'b0, dv);  chk("R1 dsp status", 32'(dv), 32'h02);
    drd(2'd2, 1'b0, dv);  chk("R1 receive", 32'(dv), 32'h0);
    chk("R1 irq", 32'(d_irq), 32'h0);

    // R2 R3 R4 R6 R10 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      hwr(3'd0, VEC[i][32:25]);
      dwr(2'd0, {16'h0, VEC[i][24:17]});
      idle(2);
      hrd(3'd0, hv);       chk("R4 ctl readback", 32'(hv), 32'(VEC[i][32:25] & 8'h0F));
      hrd(3'd2, hv);       chk("R3 R4 R10 host status", 32'(hv), 32'(VEC[i][16:9]));
      drd(2'd1, 1'b0, dv); chk("R2 R4 R6 dsp status", 32'(dv), 32'(VEC[i][8:1]));
      chk("R11 irq", 32'(d_irq), 32'(VEC[i][0]));
    end
    hwr(3'd0, 8'h00);
    dwr(2'd0, 24'h0);
    idle(2);

    // R12 upper bytes alone start nothing
    hwr(3'd5, 8'hAB);
    hwr(3'd6, 8'hCD);
    idle(2);
    hrd(3'd2, hv);       chk("R12 host status", 32'(hv), 32'h06);
    drd(2'd1, 1'b0, dv); chk("R12 dsp status", 32'(dv), 32'h02);

    // R7 R10 R13 low byte write and one-cycle transfer
    hwr(3'd7, 8'hEF);
    hrd(3'd2, hv);       chk("R7 R13 pending shown", 32'(hv), 32'h00);
    hrd(3'd2, hv);       chk("R7 R10 moved", 32'(hv), 32'h02);
    drd(2'd1, 1'b0, dv); chk("R7 rx full", 32'(dv), 32'h03);
    drd(2'd2, 1'b0, dv); chk("R7 packed word", 32'(dv), 32'hABCDEF);

    // R8 second word stalls behind full receive register
    hwr(3'd5, 8'h11);
    hwr(3'd6, 8'h22);
    hwr(3'd7, 8'h33);
    idle(3);
    hrd(3'd2, hv);       chk("R8 host status", 32'(hv), 32'h00);
    drd(2'd2, 1'b0, dv); chk("R8 held word", 32'(dv), 32'hABCDEF);
    drd(2'd1, 1'b0, dv); chk("R8 dsp status", 32'(dv), 32'h03);

    // R9 draining read releases the pending word
    drd(2'd2, 1'b1, dv); chk("R9 drain value", 32'(dv), 32'hABCDEF);
    idle(2);
    drd(2'd2, 1'b0, dv); chk("R9 next word", 32'(dv), 32'h112233);
    drd(2'd1, 1'b0, dv); chk("R9 full again", 32'(dv), 32'h03);
    drd(2'd2, 1'b1, dv);
    idle(1);
    drd(2'd1, 1'b0, dv); chk("R9 empty", 32'(dv), 32'h02);
    hrd(3'd2, hv);       chk("R9 R10 ready", 32'(hv), 32'h06);

    // R11 receive interrupt
    dwr(2'd0, 24'h000001);
    hwr(3'd7, 8'h44);
    idle(3);
    chk("R11 rx irq set", 32'(d_irq), 32'h1);
    drd(2'd2, 1'b1, dv); chk("R7 relaunched word", 32'(dv), 32'h112244);
    idle(2);
    chk("R11 rx irq clear", 32'(d_irq), 32'h0);
    dwr(2'd0, 24'h0);

    // R13 unmapped host offsets
    hrd(3'd1, hv); chk("R13 offset 1", 32'(hv), 32'h0);
    hrd(3'd4, hv); chk("R13 offset 4", 32'(hv), 32'h0);
    hrd(3'd7, hv); chk("R13 offset 7", 32'(hv), 32'h0);

    // R5 stop keeps flags, drops mode
    hwr(3'd0, 8'h0D);
    idle(1);
    drd(2'd1, 1'b0, dv); chk("R5 dma on", 32'(dv), 32'h8A);
    chk("R6 reserved zero", 32'(dv[6:5]), 32'h0);
    pulse(0);
    idle(1);
    drd(2'd1, 1'b0, dv); chk("R5 stop dsp status", 32'(dv), 32'h0A);
    hrd(3'd0, hv);       chk("R5 stop ctl", 32'(hv), 32'h01);
    hrd(3'd2, hv);       chk("R5 stop host status", 32'(hv), 32'h06);

    // R5 soft reset
    hwr(3'd0, 8'h0B);
    dwr(2'd0, 24'h000018);
    pulse(1);
    idle(1);
    hrd(3'd0, hv);       chk("R5 soft ctl", 32'(hv), 32'h00);
    hrd(3'd2, hv);       chk("R5 soft host status", 32'(hv), 32'h06);

    // R5 unit reset also empties a full receive path
    hwr(3'd0, 8'h04);
    hwr(3'd7, 8'h55);
    idle(2);
    pulse(2);
    idle(1);
    drd(2'd1, 1'b0, dv); chk("R5 unit dsp status", 32'(dv), 32'h02);
    drd(2'd2, 1'b0, dv); chk("R5 unit receive", 32'(dv), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule